// File: doc/BRIEF.md
# Transit Fare Card Entry Validator

This block decides whether a passenger may pass the entry gate of a station. When a start pulse arrives with the entry task selected, it captures a 16-bit card word, the gate's 4-bit station number and the station clock's peak indication. It checks that the card carries the valid header and that the card has not already been stamped for a journey. It also checks that the balance covers the cheapest one-way trip for the current time of day.

One cycle later the block raises a single-cycle done pulse. On acceptance, the same cycle also carries a gate-open decision, a card write strobe and the word to write back. That word keeps the header and the balance, and fills in the time-of-day bit and this station's number. Reading and writing the card serially, topping up funds and deducting the exit fare are handled elsewhere.

Top module: `fare_entry_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done`, `gate_open` and `card_wr` are 0 and `card_out` is all zeros.
- R2: A cycle with `start`=1 and `task_code`=00 produces `done`=1 in exactly the next cycle, and only then. A start with any other task code (01, 10, 11) produces no `done`.
- R3: The card fields are laid out from bit 15 down: header in bits 15..12, balance in bits 11..5, time stamp in bit 4 and station number in bits 3..0. A header other than 1010 is rejected.
- R4: A card whose time stamp bit or station field is nonzero at entry is rejected.
- R5: The balance counts in quarter units. The minimum accepted balance is 5 when `peak`=0 and 7 when `peak`=1, which is the base fare of 4 or 6 plus one station. A balance equal to the minimum is accepted, and one unit below it is rejected.
- R6: On acceptance, the done cycle has `gate_open`=1 and `card_wr`=1. In that cycle `card_out` equals the sampled header and balance, followed by the sampled `peak` in bit 4 and the sampled `station_id` in bits 3..0.
- R7: On rejection, the done cycle has `gate_open`=0, `card_wr`=0 and `card_out` all zeros.
- R8: `gate_open` and `card_wr` are 0 in every cycle where `done` is 0.
- R9: Starts in consecutive cycles each give their own result in consecutive done cycles, and each result depends only on the inputs sampled with its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Sample request, one cycle per card |
| task_code | input | 2 | Gate task; 00 selects entry validation |
| card_in | input | 16 | Card word as read from the card |
| station_id | input | 4 | Number of this station |
| peak | input | 1 | 1 during peak hours, 0 off-peak |
| done | output | 1 | One-cycle result pulse |
| gate_open | output | 1 | Gate may open (valid with done) |
| card_wr | output | 1 | Write card_out back to the card (valid with done) |
| card_out | output | 16 | Word to write to the card |

## Verification
Two events can fall in the same cycle: the done pulse of one card, and the start pulse that samples the next card. The bench provokes this by issuing starts on adjacent cycles. The pairs alternate accepting and rejecting cards and mix peak and off-peak, so a held-over decision or word would be visible. The scoreboard queues one expected result per selected start and compares each done cycle against the head of the queue in order. Any done with nothing queued is an error.

// File: rtl/fare_pkg.sv
// Shared card-word layout for the station gate logic.
// Assumes a fixed header / balance / time stamp / station layout, MSB first.
package fare_pkg;
    localparam int HDR_W  = 4;
    localparam int BAL_W  = 7;
    localparam int STN_W  = 4;
    localparam int CARD_W = HDR_W + BAL_W + 1 + STN_W;

    typedef struct packed {
        logic [HDR_W-1:0] hdr;
        logic [BAL_W-1:0] bal;
        logic             ts;
        logic [STN_W-1:0] stn;
    } card_t;
endpackage

// File: rtl/card_field_split.sv
// Checks the fixed fields of an incoming card at entry: the header must match
// the key value, and the journey fields (time stamp, station) must be clear.
// Purely combinational; assumes the caller samples the result.
module card_field_split #(
    parameter int HDR_W = 4,
    parameter int STN_W = 4,
    parameter logic [HDR_W-1:0] HDR_KEY = 4'b1010
) (
    input  logic [HDR_W-1:0] hdr,
    input  logic             ts,
    input  logic [STN_W-1:0] stn,
    output logic             hdr_ok,
    output logic             fields_clear
);
    // Header comparison and journey-field emptiness.
    always_comb begin
        hdr_ok       = (hdr == HDR_KEY);
        fields_clear = !ts && (stn == '0);
    end
endmodule

// File: rtl/entry_fare_floor.sv
// Decides whether a balance covers the cheapest trip for the time of day.
// The floor is the base fare plus MIN_HOPS station steps. Assumes all values
// are in the card's balance units. A floor that does not fit the balance
// width can never be met.
module entry_fare_floor #(
    parameter int BAL_W     = 7,
    parameter int BASE_OFF  = 4,
    parameter int BASE_PEAK = 6,
    parameter int STEP      = 1,
    parameter int MIN_HOPS  = 1
) (
    input  logic [BAL_W-1:0] bal,
    input  logic             peak,
    output logic             covers
);
    localparam int FLOOR_OFF  = BASE_OFF  + MIN_HOPS * STEP;
    localparam int FLOOR_PEAK = BASE_PEAK + MIN_HOPS * STEP;
    localparam int BAL_MAX    = (1 << BAL_W) - 1;

    logic off_ok;
    logic peak_ok;

    // One comparator per time-of-day floor; an unreachable floor ties low.
    generate
        if (FLOOR_OFF <= BAL_MAX) begin : g_off
            always_comb off_ok = (bal >= BAL_W'(FLOOR_OFF));
        end else begin : g_off_never
            always_comb off_ok = 1'b0;
        end
        if (FLOOR_PEAK <= BAL_MAX) begin : g_peak
            always_comb peak_ok = (bal >= BAL_W'(FLOOR_PEAK));
        end else begin : g_peak_never
            always_comb peak_ok = 1'b0;
        end
    endgenerate

    // Select the floor for the current time of day.
    always_comb covers = peak ? peak_ok : off_ok;
endmodule

// File: rtl/entry_result_reg.sv
// Registers one entry decision per load. Produces a one-cycle done pulse with
// gate and write strobes. The word is zero on rejection and held between
// loads. Assumes synchronous active-low reset.
module entry_result_reg #(
    parameter int CARD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              accept,
    input  logic [CARD_W-1:0] word_in,
    output logic              done,
    output logic              gate_open,
    output logic              card_wr,
    output logic [CARD_W-1:0] card_out
);
    // Capture the decision on load; the strobes last a single cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            gate_open <= 1'b0;
            card_wr   <= 1'b0;
            card_out  <= '0;
        end else begin
            done      <= load;
            gate_open <= load && accept;
            card_wr   <= load && accept;
            if (load) begin
                card_out <= accept ? word_in : '0;
            end
        end
    end

    // R8
    gate_only_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open || card_wr) |-> done);

    // R7
    reject_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !gate_open) |-> (!card_wr && card_out == '0));
endmodule

// File: rtl/fare_entry_gate.sv
// Entry gate validator. On a start with the entry task selected, it samples
// the card word, station number and peak flag. It checks the header, checks
// that the journey fields are empty and checks the minimum balance. One cycle
// later it reports the gate decision and the stamped card word.
// Assumes inputs are stable in the start cycle only.
module fare_entry_gate
    import fare_pkg::*;
#(
    parameter logic [1:0]       TASK_ENTRY = 2'b00,
    parameter logic [HDR_W-1:0] HDR_KEY    = 4'b1010,
    parameter int               BASE_OFF   = 4,
    parameter int               BASE_PEAK  = 6,
    parameter int               STEP       = 1,
    parameter int               MIN_HOPS   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        task_code,
    input  logic [CARD_W-1:0] card_in,
    input  logic [STN_W-1:0]  station_id,
    input  logic              peak,
    output logic              done,
    output logic              gate_open,
    output logic              card_wr,
    output logic [CARD_W-1:0] card_out
);
    card_t card;
    card_t stamped;
    logic  sel;
    logic  hdr_ok;
    logic  fields_clear;
    logic  covers;
    logic  accept;

    // Field view of the card, selection, and the stamped word.
    always_comb begin
        card        = card_t'(card_in);
        sel         = start && (task_code == TASK_ENTRY);
        stamped     = card;
        stamped.ts  = peak;
        stamped.stn = station_id;
        accept      = hdr_ok && fields_clear && covers;
    end

    card_field_split #(
        .HDR_W   (HDR_W),
        .STN_W   (STN_W),
        .HDR_KEY (HDR_KEY)
    ) u_fields (
        .hdr          (card.hdr),
        .ts           (card.ts),
        .stn          (card.stn),
        .hdr_ok       (hdr_ok),
        .fields_clear (fields_clear)
    );

    entry_fare_floor #(
        .BAL_W     (BAL_W),
        .BASE_OFF  (BASE_OFF),
        .BASE_PEAK (BASE_PEAK),
        .STEP      (STEP),
        .MIN_HOPS  (MIN_HOPS)
    ) u_floor (
        .bal    (card.bal),
        .peak   (peak),
        .covers (covers)
    );

    entry_result_reg #(
        .CARD_W (CARD_W)
    ) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sel),
        .accept    (accept),
        .word_in   (stamped),
        .done      (done),
        .gate_open (gate_open),
        .card_wr   (card_wr),
        .card_out  (card_out)
    );

    // R2
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && task_code == TASK_ENTRY) |=> done);

    // R2
    done_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start && task_code == TASK_ENTRY));

    // R3
    header_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_open |-> ($past(card_in[15:12]) == 4'b1010));

    // R4
    fresh_card_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_open |-> ($past(card_in[4:0]) == 5'd0));

    // R5
    min_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_open |-> ($past(card_in[11:5]) >= ($past(peak) ? 7'd7 : 7'd5)));

    // R6
    stamped_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_open |-> (card_out == {$past(card_in[15:5]), $past(peak), $past(station_id)}));
endmodule

// File: tb/fare_entry_gate_bench.sv
`timescale 1ns/1ps
module fare_entry_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  task_code = 2'b00;
    logic [15:0] card_in = '0;
    logic [3:0]  station_id = '0;
    logic        peak = 1'b0;
    logic        done;
    logic        gate_open;
    logic        card_wr;
    logic [15:0] card_out;

    int checks = 0;
    int fails  = 0;
    bit running = 1'b0;

    logic [17:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    fare_entry_gate u_fare_entry_gate (
        .clk(clk), .rst_n(rst_n), .start(start), .task_code(task_code),
        .card_in(card_in), .station_id(station_id), .peak(peak),
        .done(done), .gate_open(gate_open), .card_wr(card_wr), .card_out(card_out)
    );

    function automatic logic [15:0] mk(input logic [3:0] h, input int bal,
                                       input logic ts, input logic [3:0] s);
        return {h, 7'(bal), ts, s};
    endfunction

    // Expected {gate_open, card_wr, card_out} from the requirements.
    function automatic logic [17:0] model(input logic [15:0] c, input logic [3:0] s,
                                          input logic p);
        logic ok;
        ok = (c[15:12] == 4'b1010) && (c[4:0] == 5'd0) &&
             (c[11:5] >= (p ? 7'd7 : 7'd5));
        return ok ? {2'b11, c[15:5], p, s} : 18'd0;
    endfunction

    task automatic send(input logic [15:0] c, input logic [3:0] s, input logic p,
                        input logic [1:0] t, input string tag);
        card_in    = c;
        station_id = s;
        peak       = p;
        task_code  = t;
        start      = 1'b1;
        if (t == 2'b00) begin
            exp_q.push_back(model(c, s, p));
            tag_q.push_back(tag);
        end
        @(negedge clk);
        start     = 1'b0;
        card_in   = 16'hFFFF;
        task_code = 2'b11;
    endtask

    // Monitor / scoreboard, sampled on the falling edge.
    always @(negedge clk) begin
        if (running) begin
            if (done) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R2 unexpected done: got done=1 expected done=0");
                end else begin
                    logic [17:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if ({gate_open, card_wr, card_out} != e) begin
                        fails++;
                        $display("FAIL %s: got gate=%0b wr=%0b word=%h expected gate=%0b wr=%0b word=%h",
                                 t, gate_open, card_wr, card_out, e[17], e[16], e[15:0]);
                    end
                end
            end else begin
                checks++;
                if (gate_open || card_wr) begin
                    fails++;
                    $display("FAIL R8 strobe outside done: got gate=%0b wr=%0b expected 0 0",
                             gate_open, card_wr);
                end
            end
        end
    end

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got no end expected end of run");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (done || gate_open || card_wr || card_out != 16'd0) begin
            fails++;
            $display("FAIL R1 in reset: got %0b%0b%0b %h expected 000 0000",
                     done, gate_open, card_wr, card_out);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (done || gate_open || card_wr || card_out != 16'd0) begin
            fails++;
            $display("FAIL R1 after reset: got %0b%0b%0b %h expected 000 0000",
                     done, gate_open, card_wr, card_out);
        end
        running = 1'b1;

        send(mk(4'b1010, 5, 1'b0, 4'd0), 4'd3, 1'b0, 2'b00, "R5 off-peak floor 5 accept");
        @(negedge clk);
        send(mk(4'b1010, 4, 1'b0, 4'd0), 4'd3, 1'b0, 2'b00, "R5 off-peak 4 reject");
        @(negedge clk);
        send(mk(4'b1010, 7, 1'b0, 4'd0), 4'd9, 1'b1, 2'b00, "R5 peak floor 7 accept");
        @(negedge clk);
        send(mk(4'b1010, 6, 1'b0, 4'd0), 4'd9, 1'b1, 2'b00, "R5 peak 6 reject");
        @(negedge clk);
        send(mk(4'b1011, 100, 1'b0, 4'd0), 4'd2, 1'b0, 2'b00, "R3 bad header reject");
        @(negedge clk);
        send(mk(4'b0101, 100, 1'b0, 4'd0), 4'd2, 1'b1, 2'b00, "R3 inverted header reject");
        @(negedge clk);
        send(mk(4'b1010, 100, 1'b1, 4'd0), 4'd2, 1'b0, 2'b00, "R4 time stamp set reject");
        @(negedge clk);
        send(mk(4'b1010, 100, 1'b0, 4'd6), 4'd2, 1'b0, 2'b00, "R4 station set reject");
        @(negedge clk);
        send(mk(4'b1010, 127, 1'b0, 4'd0), 4'd15, 1'b1, 2'b00, "R6 full balance stamp");
        @(negedge clk);
        send(mk(4'b1010, 17, 1'b0, 4'd0), 4'd0, 1'b0, 2'b00, "R6 station 0 off-peak stamp");
        @(negedge clk);
        // R7 reject after an accept must clear the word.
        send(mk(4'b1010, 0, 1'b0, 4'd0), 4'd5, 1'b1, 2'b00, "R7 empty card reject");
        @(negedge clk);
        // R2 other task codes give no done.
        send(mk(4'b1010, 50, 1'b0, 4'd0), 4'd1, 1'b0, 2'b01, "R2 task 01");
        send(mk(4'b1010, 50, 1'b0, 4'd0), 4'd1, 1'b0, 2'b10, "R2 task 10");
        send(mk(4'b1010, 50, 1'b0, 4'd0), 4'd1, 1'b0, 2'b11, "R2 task 11");
        repeat (2) @(negedge clk);
        // R9 back-to-back starts.
        send(mk(4'b1010, 40, 1'b0, 4'd0), 4'd12, 1'b1, 2'b00, "R9 pair first accept");
        send(mk(4'b1010, 5, 1'b0, 4'd0), 4'd4, 1'b1, 2'b00, "R9 pair second reject");
        send(mk(4'b1010, 5, 1'b0, 4'd0), 4'd7, 1'b0, 2'b00, "R9 pair third accept");
        send(mk(4'b1110, 90, 1'b0, 4'd0), 4'd7, 1'b0, 2'b00, "R9 pair fourth reject");
        send(mk(4'b1010, 8, 1'b0, 4'd0), 4'd11, 1'b1, 2'b00, "R9 pair fifth accept");
        repeat (4) @(negedge clk);

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2 missing done: got %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule